// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment base and a 16-bit offset into a 20-bit physical memory address. It keeps four 16-bit segment registers: code, stack, data and extra. A requester presents an access kind and the offset for the access, such as the instruction pointer, the stack pointer or an index register, together with a one-cycle request strobe. The block picks the segment register that this kind of access uses by default, or the one named on the override inputs when an override is valid. It appends four zero bits to the right of the segment value, adds the offset and registers the result.

Software reads and writes the segment registers through a small select, write-enable and data port. A write changes the address of every request that is strobed after the write's clock edge. The sum is taken modulo 2^20, so an address that runs past the top of the 1 MB space wraps to the bottom.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, all four segment registers read zero, `addr_valid` is 0 and `addr_out` is 00000h.
- R2: The address is (segment × 16 + offset) taken in 20 bits. Segment 08F1h with offset 0100h gives 09010h, and segment 002Ah with offset 0023h gives 002C3h.
- R3: A carry out of bit 19 is dropped. Segment FFFFh with offset 0010h gives 00000h, and with offset 000Fh it gives FFFFFh.
- R4: Access kind 00 (instruction fetch) uses the code segment register when no override is valid.
- R5: Access kind 01 (stack) uses the stack segment register when no override is valid.
- R6: Access kinds 10 and 11 (data) use the data segment register when no override is valid.
- R7: While `ovr_valid` is 1, the register named by `ovr_seg` replaces the default (00 code, 01 stack, 10 data, 11 extra). While `ovr_valid` is 0, `ovr_seg` has no effect.
- R8: `addr_valid` is 1 in exactly the cycle after a cycle in which `req_valid` was sampled high. `addr_out` holds its value when no request is sampled.
- R9: `reg_we` writes `reg_wdata` into the register chosen by `reg_sel` (00 code, 01 stack, 10 data, 11 extra). `reg_rdata` shows the selected register without delay. A request sampled at the same edge as a write uses the old value, and the next request uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Segment register write enable |
| reg_sel | input | 2 | Segment register select for write and read |
| reg_wdata | input | 16 | Value to write |
| reg_rdata | output | 16 | Current value of the selected register |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Access kind: 00 fetch, 01 stack, 10/11 data |
| req_offset | input | 16 | Offset for this access |
| ovr_valid | input | 1 | Override the default segment |
| ovr_seg | input | 2 | Segment register to use on an override |
| addr_valid | output | 1 | Address valid, one cycle after the strobe |
| addr_out | output | 20 | Registered physical address |

## Verification
The address and its valid flag are each due one clock after the edge that samples the request. The bench therefore drives on the falling edge, waits for one rising edge and reads the result at the next falling edge. It looks again a cycle later to see that the valid flag has dropped and the address is holding. The register read port has no delay, so the bench reads it a short settling time after changing the select. To check the ordering between a write and a request that share an edge, the bench compares the result of that request with the result of the request after it.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int NUM_SEG = 4;
  localparam int SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    SEG_CODE  = 2'b00,
    SEG_STACK = 2'b01,
    SEG_DATA  = 2'b10,
    SEG_EXTRA = 2'b11
  } seg_id_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_STACK = 2'b01,
    ACC_DATA  = 2'b10,
    ACC_DATA2 = 2'b11
  } acc_kind_e;

  // Segment used when the requester does not override
  function automatic seg_id_e default_seg(input acc_kind_e kind);
    case (kind)
      ACC_FETCH: return SEG_CODE;
      ACC_STACK: return SEG_STACK;
      default:   return SEG_DATA;
    endcase
  endfunction
endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/seg_regfile.sv
module seg_regfile #(
  parameter int SEG_W   = 16,
  parameter int NUM_SEG = 4,
  parameter int SEL_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] sw_sel,
  output logic [SEG_W-1:0] sw_data,
  input  logic [SEL_W-1:0] lk_sel,
  output logic [SEG_W-1:0] lk_data
);
  logic [SEG_W-1:0] seg_q [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic             load;
    logic [SEG_W-1:0] d, q;

    always_comb begin
      load = wr_en && (wr_sel == SEL_W'(g));
      d    = load ? wr_data : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign seg_q[g] = q;
  end

  assign sw_data = seg_q[sw_sel];
  assign lk_data = seg_q[lk_sel];
endmodule

// File: rtl/seg_pick.sv
module seg_pick
  import seg_addr_pkg::*;
(
  input  logic [1:0]       kind,
  input  logic             ovr_valid,
  input  logic [SEL_W-1:0] ovr_seg,
  output logic [SEL_W-1:0] seg_sel
);
  always_comb begin
    if (ovr_valid) seg_sel = ovr_seg;
    else           seg_sel = default_seg(acc_kind_e'(kind));
  end
endmodule

// File: rtl/seg_addr_stage.sv
module seg_addr_stage #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  seg_val,
  input  logic [OFF_W-1:0]  off_val,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr_out
);
  logic [ADDR_W-1:0] base, sum, addr_d;
  logic              valid_d;

  always_comb begin
    base    = ADDR_W'({seg_val, {SHIFT{1'b0}}});
    sum     = base + ADDR_W'(off_val);
    addr_d  = req_valid ? sum : addr_out;
    valid_d = req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_out   <= '0;
      addr_valid <= 1'b0;
    end else begin
      addr_out   <= addr_d;
      addr_valid <= valid_d;
    end
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = SEG_W + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [SEG_W-1:0]  reg_wdata,
  output logic [SEG_W-1:0]  reg_rdata,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic              ovr_valid,
  input  logic [SEL_W-1:0]  ovr_seg,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr_out
);
  logic             rst_core_n;
  logic [SEL_W-1:0] pick_sel;
  logic [SEG_W-1:0] pick_val;

  seg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  seg_regfile #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG), .SEL_W(SEL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (reg_we),
    .wr_sel  (reg_sel),
    .wr_data (reg_wdata),
    .sw_sel  (reg_sel),
    .sw_data (reg_rdata),
    .lk_sel  (pick_sel),
    .lk_data (pick_val)
  );

  seg_pick u_pick (
    .kind      (req_kind),
    .ovr_valid (ovr_valid),
    .ovr_seg   (ovr_seg),
    .seg_sel   (pick_sel)
  );

  seg_addr_stage #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_stage (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .req_valid  (req_valid),
    .seg_val    (pick_val),
    .off_val    (req_offset),
    .addr_valid (addr_valid),
    .addr_out   (addr_out)
  );
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = SEG_W + SHIFT
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              reg_we,
  input logic [1:0]        reg_sel,
  input logic [SEG_W-1:0]  reg_wdata,
  input logic [SEG_W-1:0]  reg_rdata,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic [OFF_W-1:0]  req_offset,
  input logic              ovr_valid,
  input logic [1:0]        ovr_seg,
  input logic              addr_valid,
  input logic [ADDR_W-1:0] addr_out
);
  function automatic logic [ADDR_W-1:0] phys(input logic [SEG_W-1:0] s,
                                             input logic [OFF_W-1:0] o);
    return ADDR_W'({s, {SHIFT{1'b0}}}) + ADDR_W'(o);
  endfunction

  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(rst_core_n) |-> (!addr_valid && addr_out == '0));

  p_valid_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    req_valid |=> addr_valid);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    !req_valid |=> (!addr_valid && $stable(addr_out)));

  p_write_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    reg_we |=> (reg_sel != $past(reg_sel) || reg_rdata == $past(reg_wdata)));

  // R2 and R3: the sum form holds for every kind checked below
  p_fetch_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && !ovr_valid && req_kind == 2'b00 && reg_sel == 2'b00)
      |=> addr_out == phys($past(reg_rdata), $past(req_offset)));

  p_stack_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && !ovr_valid && req_kind == 2'b01 && reg_sel == 2'b01)
      |=> addr_out == phys($past(reg_rdata), $past(req_offset)));

  p_data_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && !ovr_valid && req_kind[1] && reg_sel == 2'b10)
      |=> addr_out == phys($past(reg_rdata), $past(req_offset)));

  p_override_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && ovr_valid && reg_sel == ovr_seg)
      |=> addr_out == phys($past(reg_rdata), $past(req_offset)));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .reg_we     (reg_we),
  .reg_sel    (reg_sel),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .req_valid  (req_valid),
  .req_kind   (req_kind),
  .req_offset (req_offset),
  .ovr_valid  (ovr_valid),
  .ovr_seg    (ovr_seg),
  .addr_valid (addr_valid),
  .addr_out   (addr_out)
);

// File: tb/sim_seg_addr_gen.sv
`timescale 1ns/1ps
module sim_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'b00;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b00;
  logic [15:0] req_offset = '0;
  logic        ovr_valid = 1'b0;
  logic [1:0]  ovr_seg = 2'b00;
  logic        addr_valid;
  logic [19:0] addr_out;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  seg_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_kind(req_kind), .req_offset(req_offset), .ovr_valid(ovr_valid),
    .ovr_seg(ovr_seg), .addr_valid(addr_valid), .addr_out(addr_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // One request; result sampled one clock later
  task automatic req(input string tag, input logic [1:0] kind, input logic [15:0] off,
                     input logic ov, input logic [1:0] os, input logic [19:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_offset = off; ovr_valid = ov; ovr_seg = os;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; ovr_valid = 1'b0;
    check(tag, 32'(addr_valid), 32'd1);
    check(tag, 32'(addr_out), 32'(exp));
  endtask

  task automatic t_reset;
    check("R1 valid", 32'(addr_valid), 32'd0);
    check("R1 addr", 32'(addr_out), 32'd0);
    for (int i = 0; i < 4; i++) begin
      reg_sel = 2'(i);
      #1;
      check("R1 seg", 32'(reg_rdata), 32'd0);
    end
  endtask

  task automatic t_examples;
    wr(2'b00, 16'h08F1);
    #1;
    check("R9 readback", 32'(reg_rdata), 32'h08F1);
    req("R2 example A", 2'b00, 16'h0100, 1'b0, 2'b00, 20'h09010);
    wr(2'b10, 16'h002A);
    req("R2 example B", 2'b10, 16'h0023, 1'b0, 2'b00, 20'h002C3);
  endtask

  task automatic t_wrap;
    wr(2'b01, 16'hFFFF);
    req("R3 wrap", 2'b01, 16'h0010, 1'b0, 2'b00, 20'h00000);
    req("R3 top", 2'b01, 16'h000F, 1'b0, 2'b00, 20'hFFFFF);
  endtask

  task automatic t_kinds;
    wr(2'b00, 16'h1000);
    wr(2'b01, 16'h2000);
    wr(2'b10, 16'h3000);
    wr(2'b11, 16'h4000);
    req("R4 fetch", 2'b00, 16'h0005, 1'b0, 2'b00, 20'h10005);
    req("R5 stack", 2'b01, 16'h0005, 1'b0, 2'b00, 20'h20005);
    req("R6 data", 2'b10, 16'h0005, 1'b0, 2'b00, 20'h30005);
    req("R6 data alt", 2'b11, 16'h0005, 1'b0, 2'b00, 20'h30005);
  endtask

  task automatic t_override;
    req("R7 extra", 2'b00, 16'h0005, 1'b1, 2'b11, 20'h40005);
    req("R7 code", 2'b10, 16'h0005, 1'b1, 2'b00, 20'h10005);
    req("R7 ignored", 2'b01, 16'h0005, 1'b0, 2'b11, 20'h20005);
  endtask

  task automatic t_timing;
    req("R8 strobe", 2'b00, 16'h0ABC, 1'b0, 2'b00, 20'h10ABC);
    @(negedge clk);
    check("R8 valid drop", 32'(addr_valid), 32'd0);
    check("R8 hold", 32'(addr_out), 32'h10ABC);
  endtask

  task automatic t_write_order;
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'b00; reg_wdata = 16'h5000;
    req_valid = 1'b1; req_kind = 2'b00; req_offset = 16'h0000; ovr_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; req_valid = 1'b0;
    check("R9 same edge old value", 32'(addr_out), 32'h10000);
    req("R9 next uses new", 2'b00, 16'h0000, 1'b0, 2'b00, 20'h50000);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_examples();
    t_wrap();
    t_kinds();
    t_override();
    t_timing();
    t_write_order();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule